// File: doc/BRIEF.md
# Pulse-Pause Bit Transmitter

This block sends a short frame from a reader to a card by switching a single carrier-enable line. Each bit opens with a fixed low gap. The carrier then comes back on, and the bit's value is carried by how long the whole symbol lasts: a long symbol stands for one and a short symbol for zero. Every bit is whitened on the way out. The block XORs it with a keystream bit from an outside cipher and strobes that cipher once per bit so it moves to its next bit. After the final data bit the block emits one more isolated low gap as the end-of-frame marker, and then leaves the carrier on.

All durations are measured in ticks of a timebase clock enable, so the same logic serves any system clock. One saturating tick counter times every gap and symbol. The counter restarts at frame end and keeps counting while the block is idle. This gives the surrounding receiver a timebase that starts at the close of the frame, which it uses to open its reply window.

Top module: `pulse_pause_tx`

## Requirements
- R1: After reset the carrier output is high, and busy, done and the keystream strobe are low.
- R2: The block transmits data bits least significant first, taking bit 0 of the data word first.
- R3: Every bit begins with the carrier low for exactly PAUSE_TICKS ticks, and then the carrier returns high.
- R4: A symbol of one lasts ONE_TICKS ticks from the start of its low gap to the start of the next gap. A symbol of zero lasts ZERO_TICKS ticks.
- R5: The symbol sent for bit i is data bit i XOR the keystream input. The keystream input is sampled at the clock edge that ends that bit's low gap.
- R6: The keystream strobe is a single-cycle pulse, once per bit, in the first cycle of the bit's high part. A frame produces exactly as many strobes as it sends bits.
- R7: After the last bit the carrier goes low for one more gap of PAUSE_TICKS ticks and then stays high. The done output is high for one cycle, and that cycle is the first cycle in which the carrier is high again.
- R8: Busy is high from the cycle after an accepted start through the last cycle of the end-of-frame gap, and it is low in the done cycle. A start pulse that arrives while busy is high has no effect on the frame or on anything that follows it.
- R9: A bit count of zero produces only the end-of-frame gap, followed by done.
- R10: A bit count larger than MAX_BITS is treated as MAX_BITS.
- R11: The idle_ticks output is 0 in the done cycle. After that it rises by one at each tick, and it holds at 2^TIMER_W-1 once it gets there.
- R12: Timing advances only on cycles where tick_en is high, so every duration above holds in ticks however sparse the ticks are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase enable; one tick per high cycle |
| start | input | 1 | Starts a frame when the block is idle |
| data_in | input | MAX_BITS | Frame payload, bit 0 sent first |
| nbits_in | input | $clog2(MAX_BITS+1) | Number of bits to send |
| ks_bit | input | 1 | Current keystream bit from the external cipher |
| ks_step | output | 1 | One-cycle request to advance the keystream |
| carrier_en | output | 1 | Carrier enable; low during gaps, high otherwise |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| idle_ticks | output | TIMER_W | Ticks since the end of the last frame, saturating |

## Verification
The bench builds the block with MAX_BITS=6, PAUSE_TICKS=2, ONE_TICKS=5, ZERO_TICKS=3 and TIMER_W=4. At these values every 6-bit payload can be sent at every legal length, and at one length above the limit, at low run-time cost. The bench decodes the carrier back into ticks per gap and per symbol and compares the result against the payload, with a live keystream model running in some passes. A 4-bit timer reaches saturation after only 15 idle ticks. A one-in-three tick pattern shows that every duration is counted in ticks and not in clock cycles.

// File: rtl/pulse_pause_pkg.sv
package pulse_pause_pkg;

  // Transmit sequencer phases
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,  // carrier on, waiting for start
    TX_PAUSE = 2'd1,  // leading low gap of a data bit
    TX_HIGH  = 2'd2,  // carrier-on remainder of a data bit
    TX_TAIL  = 2'd3   // standalone end-of-frame gap
  } tx_state_e;

endpackage

// File: rtl/pp_tick_timer.sv
module pp_tick_timer #(
  parameter int TIMER_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               inc,
  output logic [TIMER_W-1:0] count
);

  localparam logic [TIMER_W-1:0] SAT_VAL = '1;

  logic [TIMER_W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (clr) begin
      count_d = '0;
    end else if (inc && (count_q != SAT_VAL)) begin
      count_d = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

  // R11: a saturated count stays put while ticks keep arriving
  assert_timer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && (count_q == SAT_VAL)) |=> (count_q == SAT_VAL));

endmodule

// File: rtl/pp_bit_shifter.sv
module pp_bit_shifter #(
  parameter int MAX_BITS = 32,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                shift,
  input  logic [MAX_BITS-1:0] data_in,
  input  logic [CNT_W-1:0]    nbits_in,
  output logic                cur_bit,
  output logic                last_bit,
  output logic                load_empty
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BITS);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  logic [MAX_BITS-1:0] word_q, word_d;
  logic [CNT_W-1:0]    left_q, left_d;
  logic [CNT_W-1:0]    nbits_eff;

  // R10: oversize counts clamp to the register width
  assign nbits_eff  = (nbits_in > MAX_CNT) ? MAX_CNT : nbits_in;
  assign load_empty = (nbits_eff == '0);

  always_comb begin
    word_d = word_q;
    left_d = left_q;
    if (load) begin
      word_d = data_in;
      left_d = nbits_eff;
    end else if (shift) begin
      word_d = word_q >> 1;
      left_d = left_q - ONE_CNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
    end else begin
      word_q <= word_d;
      left_q <= left_d;
    end
  end

  assign cur_bit  = word_q[0];
  assign last_bit = (left_q == ONE_CNT);

  // R2: the sequencer never consumes a bit that was not loaded
  assert_shift_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (left_q != '0));

  // R8: a new frame is never loaded while a bit is being retired
  assert_no_load_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));

endmodule

// File: rtl/pulse_pause_tx.sv
module pulse_pause_tx
  import pulse_pause_pkg::*;
#(
  parameter int MAX_BITS    = 32,
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 150,
  parameter int ZERO_TICKS  = 90,
  parameter int TIMER_W     = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tick_en,
  input  logic                            start,
  input  logic [MAX_BITS-1:0]             data_in,
  input  logic [$clog2(MAX_BITS+1)-1:0]   nbits_in,
  input  logic                            ks_bit,
  output logic                            ks_step,
  output logic                            carrier_en,
  output logic                            busy,
  output logic                            done,
  output logic [TIMER_W-1:0]              idle_ticks
);

  localparam int CNT_W = $clog2(MAX_BITS+1);
  localparam logic [TIMER_W-1:0] PAUSE_END = TIMER_W'(PAUSE_TICKS - 1);
  localparam logic [TIMER_W-1:0] ONE_END   = TIMER_W'(ONE_TICKS - 1);
  localparam logic [TIMER_W-1:0] ZERO_END  = TIMER_W'(ZERO_TICKS - 1);

  tx_state_e          state_q, state_d;
  logic               sym_q, sym_d;
  logic               ks_step_q, done_q;
  logic               step_d, done_d;
  logic               timer_clr, shift_load, shift_go;
  logic               cur_bit, last_bit, load_empty;
  logic [TIMER_W-1:0] tcount;
  logic [TIMER_W-1:0] bit_end;

  pp_tick_timer #(
    .TIMER_W (TIMER_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (timer_clr),
    .inc   (tick_en),
    .count (tcount)
  );

  pp_bit_shifter #(
    .MAX_BITS (MAX_BITS),
    .CNT_W    (CNT_W)
  ) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (shift_load),
    .shift      (shift_go),
    .data_in    (data_in),
    .nbits_in   (nbits_in),
    .cur_bit    (cur_bit),
    .last_bit   (last_bit),
    .load_empty (load_empty)
  );

  assign bit_end = sym_q ? ONE_END : ZERO_END;

  // Next-state logic: each phase ends on a tick at its final count
  always_comb begin
    state_d    = state_q;
    sym_d      = sym_q;
    step_d     = 1'b0;
    done_d     = 1'b0;
    timer_clr  = 1'b0;
    shift_load = 1'b0;
    shift_go   = 1'b0;
    case (state_q)
      TX_IDLE: begin
        if (start) begin
          shift_load = 1'b1;
          timer_clr  = 1'b1;
          state_d    = load_empty ? TX_TAIL : TX_PAUSE;
        end
      end
      TX_PAUSE: begin
        if (tick_en && (tcount == PAUSE_END)) begin
          sym_d   = cur_bit ^ ks_bit;
          step_d  = 1'b1;
          state_d = TX_HIGH;
        end
      end
      TX_HIGH: begin
        if (tick_en && (tcount == bit_end)) begin
          timer_clr = 1'b1;
          shift_go  = 1'b1;
          state_d   = last_bit ? TX_TAIL : TX_PAUSE;
        end
      end
      TX_TAIL: begin
        if (tick_en && (tcount == PAUSE_END)) begin
          timer_clr = 1'b1;
          done_d    = 1'b1;
          state_d   = TX_IDLE;
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= TX_IDLE;
      sym_q     <= 1'b0;
      ks_step_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      sym_q     <= sym_d;
      ks_step_q <= step_d;
      done_q    <= done_d;
    end
  end

  assign carrier_en = (state_q != TX_PAUSE) && (state_q != TX_TAIL);
  assign busy       = (state_q != TX_IDLE);
  assign ks_step    = ks_step_q;
  assign done       = done_q;
  assign idle_ticks = tcount;

  // R6: keystream strobe is one cycle wide
  assert_step_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ks_step |=> !ks_step);

  // R6: strobe coincides with the carrier coming back on inside a bit
  assert_step_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ks_step |-> ($rose(carrier_en) && busy));

  // R7: done marks the first carrier-on cycle after the closing gap
  assert_done_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(carrier_en) && !busy));

  // R7: done is a single-cycle pulse
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: the timebase restarts at frame end
  assert_timer_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (idle_ticks == '0));

  // R3: the carrier can only drop while a frame is active
  assert_gap_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier_en) |-> $past(busy || start));

endmodule

// File: tb/pulse_pause_tx_tb.sv
module pulse_pause_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAXB  = 6;
  localparam int PT    = 2;
  localparam int OT    = 5;
  localparam int ZT    = 3;
  localparam int TW    = 4;
  localparam int SATV  = 15;

  logic            clk;
  logic            rst_n;
  logic            tick_en;
  logic            start;
  logic [MAXB-1:0] data_in;
  logic [2:0]      nbits_in;
  logic            ks_bit;
  logic            ks_step;
  logic            carrier_en;
  logic            busy;
  logic            done;
  logic [TW-1:0]   idle_ticks;

  int   n_checks;
  int   n_errs;
  int   tick_mode;
  bit   ks_on;
  logic [7:0] lfsr;

  pulse_pause_tx #(
    .MAX_BITS    (MAXB),
    .PAUSE_TICKS (PT),
    .ONE_TICKS   (OT),
    .ZERO_TICKS  (ZT),
    .TIMER_W     (TW)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .start      (start),
    .data_in    (data_in),
    .nbits_in   (nbits_in),
    .ks_bit     (ks_bit),
    .ks_step    (ks_step),
    .carrier_en (carrier_en),
    .busy       (busy),
    .done       (done),
    .idle_ticks (idle_ticks)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // External cipher model: advances on each strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 8'hA5;
    else if (ks_step) lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[4], lfsr[7:1]};
  end
  assign ks_bit = ks_on ? lfsr[0] : 1'b0;

  // Timebase: every cycle, or one cycle in three; updated just after the edge
  initial begin
    int ph;
    ph = 0;
    tick_en = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      if (tick_mode == 0) begin
        tick_en = 1'b1;
      end else begin
        tick_en = (ph == 0);
        ph = (ph == 2) ? 0 : ph + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [MAXB-1:0] d, input int nb, input bit inject);
    int low_t[16];
    int high_t[16];
    bit ksrec[16];
    int nlow, nhigh, steps, step_bad, busy_bad, cycles, ticks, nexp;
    bit prev, cur, done_seen, done_ok, shape_ok, len_ok;
    logic [MAXB-1:0] dec, kw, mask;
    nlow = 0; nhigh = 0; steps = 0; step_bad = 0; busy_bad = 0;
    cycles = 0; ticks = 0; done_seen = 0; done_ok = 0;
    for (int i = 0; i < 16; i++) begin low_t[i] = 0; high_t[i] = 0; ksrec[i] = 0; end
    nexp = (nb > MAXB) ? MAXB : nb;
    @(negedge clk);
    data_in = d; nbits_in = nb[2:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prev = 1'b1;
    for (int c = 0; c < 2000; c++) begin
      cur = carrier_en;
      if (inject && c == 3) begin start = 1'b1; data_in = ~d; nbits_in = 3'd1; end
      if (inject && c == 4) begin start = 1'b0; data_in = d; nbits_in = nb[2:0]; end
      if (!cur && prev) nlow++;
      if (cur && !prev) nhigh++;
      if (ks_step) begin
        steps++;
        if (!(cur && !prev)) step_bad++;
      end
      if (done) begin
        done_seen = 1;
        done_ok = cur && !prev && !busy;
        break;
      end
      if (!busy) busy_bad++;
      cycles++;
      if (tick_en) begin
        ticks++;
        if (!cur && nlow > 0) low_t[nlow-1]++;
        if (cur && nhigh > 0) high_t[nhigh-1]++;
      end
      if (!cur && nlow > 0) ksrec[nlow-1] = ks_bit;
      prev = cur;
      @(negedge clk);
    end
    shape_ok = (nlow == nexp + 1);
    for (int i = 0; i < nexp; i++) if (low_t[i] != PT) shape_ok = 0;
    chk(shape_ok, "R3 gap count/length", nlow, nexp + 1);
    chk(done_seen && done_ok && low_t[nexp] == PT, "R7 end-of-frame gap and done", low_t[nexp], PT);
    len_ok = 1;
    dec = '0; kw = '0;
    for (int i = 0; i < nexp; i++) begin
      if (high_t[i] != OT - PT && high_t[i] != ZT - PT) len_ok = 0;
      dec[i] = (high_t[i] == OT - PT);
      kw[i]  = ksrec[i];
    end
    chk(len_ok, "R4 symbol lengths", high_t[0], OT - PT);
    mask = MAXB'((1 << nexp) - 1);
    if (ks_on)
      chk(((dec ^ kw) & mask) == (d & mask), "R5 keystream whitening", int'(dec), int'((d ^ kw) & mask));
    else
      chk((dec & mask) == (d & mask), "R2 LSB-first payload", int'(dec), int'(d & mask));
    chk(steps == nexp && step_bad == 0, "R6 keystream strobes", steps, nexp);
    chk(busy_bad == 0, "R8 busy span", busy_bad, 0);
    if (nb == 0) chk(nlow == 1, "R9 empty frame", nlow, 1);
    if (nb > MAXB) chk(nexp == MAXB && shape_ok, "R10 clamped count", nlow - 1, MAXB);
    if (tick_mode != 0) chk(shape_ok && len_ok && cycles >= 2 * ticks, "R12 tick-based timing", cycles, 3 * ticks);
  endtask

  initial begin
    n_checks = 0; n_errs = 0;
    tick_mode = 0; ks_on = 0;
    rst_n = 1'b0; start = 1'b0; data_in = '0; nbits_in = '0;
    repeat (3) @(negedge clk);
    chk(carrier_en == 1'b1, "R1 carrier in reset", int'(carrier_en), 1);
    chk(busy == 1'b0 && done == 1'b0 && ks_step == 1'b0, "R1 flags in reset",
        int'({busy, done, ks_step}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(carrier_en && !busy && !done && !ks_step, "R1 idle after reset",
        int'({carrier_en, busy, done, ks_step}), 8);

    // Exhaustive payload sweep at every length, plus one oversize count
    for (int nb = 0; nb <= 7; nb++)
      for (int d = 0; d < 64; d++)
        run_frame(6'(d), nb, 1'b0);

    // Live keystream
    ks_on = 1;
    for (int d = 0; d < 64; d++) run_frame(6'(d), MAXB, 1'b0);

    // Timebase restart and saturation
    ks_on = 0;
    run_frame(6'h2D, 4, 1'b0);
    chk(idle_ticks == 0, "R11 zero in done cycle", int'(idle_ticks), 0);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      chk(int'(idle_ticks) == ((k > SATV) ? SATV : k), "R11 idle count", int'(idle_ticks),
          (k > SATV) ? SATV : k);
    end

    // Start during a frame is ignored
    run_frame(6'h15, 5, 1'b1);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (busy || !carrier_en) extra++;
      end
      chk(extra == 0, "R8 no frame from ignored start", extra, 0);
    end

    // Sparse ticks
    tick_mode = 1;
    ks_on = 1;
    for (int d = 0; d < 32; d++) run_frame(6'(d * 2 + 1), (d % 7), 1'b0);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule